// File: doc/BRIEF.md
# Two-Bank Serial EEPROM Target Model

This block is a synthesizable two-wire bus target that looks like a small serial EEPROM with two banks of 256 bytes each. It oversamples the open-drain clock and data lines with the system clock. It recognises start, repeated start and stop conditions, and it pulls the data line low only through an output-enable. A single internal byte pointer is shared by every transfer. Setting the word address, writing data and reading data all use it and move it forward.

The block accepts single-byte writes and page writes. It also serves reads from the current pointer, random reads (a dummy write followed by a repeated start) and sequential reads that continue for as long as the master acknowledges. A side port lets a test environment fill and inspect the storage directly. It does not model the programming delay after a write. It does not stretch the clock and does not take part in arbitration.

Top module: `eepemu_top`

## Requirements
- R1: After reset, and whenever no transfer addressed to the block is in progress, `sda_oe` stays low.
- R2: SDA falling while SCL is high restarts control-byte decoding from any state. SDA rising while SCL is high ends the transfer. A stop that arrives after the word address but before any data byte sets the pointer and writes nothing.
- R3: The control byte is accepted only when its bits 7:4 equal 4'b1010. Bits 3:2 are ignored. Any other value is not acknowledged, and the block stays silent until the next start.
- R4: Control-byte bit 1 selects the bank (0 or 1) and bit 0 gives the direction (0 = master writes, 1 = master reads). Bank b, offset o is reached at debug address {b, o}.
- R5: Every byte the block accepts, whether control, word address or data, is acknowledged by driving SDA low during the ninth clock. The drive is switched on only while SCL is low.
- R6: A byte write (control with write, word address, one data byte, stop) stores the data at the addressed location.
- R7: During writes the pointer advances after each data byte, and only its low 4 bits wrap. A page write of more than 16 bytes therefore overwrites from the start of the same 16-byte page.
- R8: A random read (dummy write of the word address, repeated start, control with read) returns the byte at that address.
- R9: A read with no address phase returns the byte at the current pointer, which is left one past the last byte read or written.
- R10: During reads the pointer advances after each byte and wraps within the 256-byte bank. A low acknowledge from the master makes the block send the next byte.
- R11: A high acknowledge from the master after a read byte makes the block release SDA before the stop.
- R12: The debug port writes `dbg_wdata` to `dbg_addr` when `dbg_we` is high. `dbg_rdata` shows the byte at `dbg_addr` combinationally.
- R13: Bytes travel most-significant bit first in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired-AND of all drivers) |
| sda_oe | output | 1 | High pulls the data line low |
| dbg_we | input | 1 | Debug write strobe |
| dbg_addr | input | 9 | Debug address {bank, offset} |
| dbg_wdata | input | 8 | Debug write data |
| dbg_rdata | output | 8 | Byte at `dbg_addr` |

## Verification
A wrong pointer shows up at the first byte read after the fault. Page wrap and bank-wrap faults show in particular as a wrong byte at the first position after the boundary, or as a neighbouring page changed in the debug sweep. A control-decode or state fault appears within one byte time, as a missing acknowledge or as SDA still driven after the master's final no-acknowledge. Shift-order faults corrupt every byte returned by the very first read.

// File: rtl/eepemu_pkg.sv
// Shared types and constants for the EEPROM target model.
// Assumes byte-wide words and an 8-bit in-bank offset.
package eepemu_pkg;
    localparam int BYTE_W = 8;
    localparam int OFF_W  = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } eep_st_e;
endpackage

// File: rtl/eepemu_busmon.sv
// Synchronises the bus lines and reports clock edges and start/stop events.
// Assumes the bus lines are stable for several system clocks around each edge.
module eepemu_busmon #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_v,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_N:0] scl_pipe;
    logic [SYNC_N:0] sda_pipe;
    logic scl_v, scl_prev, sda_prev;

    // Shift both lines through the synchroniser and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_N-1:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_N-1:0], sda_i};
        end
    end

    assign scl_v    = scl_pipe[SYNC_N-1];
    assign scl_prev = scl_pipe[SYNC_N];
    assign sda_v    = sda_pipe[SYNC_N-1];
    assign sda_prev = sda_pipe[SYNC_N];

    assign scl_rise  = scl_v & ~scl_prev;
    assign scl_fall  = ~scl_v & scl_prev;
    assign start_det = scl_v & scl_prev & sda_prev & ~sda_v;
    assign stop_det  = scl_v & scl_prev & ~sda_prev & sda_v;
endmodule

// File: rtl/eepemu_store.sv
// Byte storage with a bus port (priority) and a debug port, both with async read.
// Assumes the two write strobes rarely coincide; the bus wins when they do.
module eepemu_store #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we_a,
    input  logic [AW-1:0] addr_a,
    input  logic [DW-1:0] wdata_a,
    output logic [DW-1:0] rdata_a,
    input  logic          we_b,
    input  logic [AW-1:0] addr_b,
    input  logic [DW-1:0] wdata_b,
    output logic [DW-1:0] rdata_b
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    // Apply one write per cycle, bus port first.
    always_ff @(posedge clk) begin
        if (we_a)
            mem[addr_a] <= wdata_a;
        else if (we_b)
            mem[addr_b] <= wdata_b;
    end

    assign rdata_a = mem[addr_a];
    assign rdata_b = mem[addr_b];
endmodule

// File: rtl/eepemu_top.sv
// Two-wire bus target behaving as a banked serial EEPROM.
// Assumes SCL low and high phases each last several system clocks; no clock stretching.
module eepemu_top
    import eepemu_pkg::*;
#(
    parameter int         BANK_W   = 1,
    parameter int         PAGE_W   = 4,
    parameter logic [3:0] DEV_CODE = 4'b1010
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    output logic                    sda_oe,
    input  logic                    dbg_we,
    input  logic [BANK_W+OFF_W-1:0] dbg_addr,
    input  logic [BYTE_W-1:0]       dbg_wdata,
    output logic [BYTE_W-1:0]       dbg_rdata
);
    localparam int AW = BANK_W + OFF_W;

    logic sda_v, scl_rise, scl_fall, start_det, stop_det;
    eep_st_e             st_q;
    logic [3:0]          bitcnt_q;
    logic [BYTE_W-1:0]   shreg_q;
    logic [OFF_W-1:0]    ptr_q;
    logic [BANK_W-1:0]   bank_q;
    logic                rd_q;
    logic                mack_q;
    logic                bus_we;
    logic [BYTE_W-1:0]   mem_rd;
    logic [OFF_W-1:0]    ptr_page_inc;
    logic                byte_done;

    eepemu_busmon #(.SYNC_N(2)) u_mon (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_v(sda_v), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    eepemu_store #(.AW(AW), .DW(BYTE_W)) u_store (
        .clk(clk),
        .we_a(bus_we), .addr_a({bank_q, ptr_q}), .wdata_a(shreg_q), .rdata_a(mem_rd),
        .we_b(dbg_we), .addr_b(dbg_addr), .wdata_b(dbg_wdata), .rdata_b(dbg_rdata)
    );

    assign byte_done    = scl_fall && (bitcnt_q == 4'd8);
    assign bus_we       = (st_q == ST_WDATA) && byte_done && !start_det && !stop_det;
    assign ptr_page_inc = {ptr_q[OFF_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + 1'b1};

    // Protocol sequencer: byte shifting, acknowledge timing and pointer upkeep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            bitcnt_q <= '0;
            shreg_q  <= '0;
            ptr_q    <= '0;
            bank_q   <= '0;
            rd_q     <= 1'b0;
            mack_q   <= 1'b0;
            sda_oe   <= 1'b0;
        end else if (start_det) begin
            st_q     <= ST_CTRL;
            bitcnt_q <= '0;
            sda_oe   <= 1'b0;
        end else if (stop_det) begin
            st_q   <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (st_q)
                ST_CTRL, ST_ADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg_q  <= {shreg_q[BYTE_W-2:0], sda_v};
                        bitcnt_q <= bitcnt_q + 1'b1;
                    end
                    if (byte_done) begin
                        bitcnt_q <= '0;
                        if (st_q == ST_CTRL) begin
                            if (shreg_q[7:4] == DEV_CODE) begin
                                bank_q <= shreg_q[BANK_W:1];
                                rd_q   <= shreg_q[0];
                                sda_oe <= 1'b1;
                                st_q   <= ST_CTRL_ACK;
                            end else begin
                                st_q <= ST_IDLE;
                            end
                        end else if (st_q == ST_ADDR) begin
                            ptr_q  <= shreg_q;
                            sda_oe <= 1'b1;
                            st_q   <= ST_ADDR_ACK;
                        end else begin
                            ptr_q  <= ptr_page_inc;
                            sda_oe <= 1'b1;
                            st_q   <= ST_WDATA_ACK;
                        end
                    end
                end
                ST_CTRL_ACK: begin
                    if (scl_fall) begin
                        if (rd_q) begin
                            shreg_q  <= mem_rd;
                            sda_oe   <= ~mem_rd[7];
                            bitcnt_q <= '0;
                            st_q     <= ST_RDATA;
                        end else begin
                            sda_oe <= 1'b0;
                            st_q   <= ST_ADDR;
                        end
                    end
                end
                ST_ADDR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                        st_q   <= ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        bitcnt_q <= bitcnt_q + 1'b1;
                        if (bitcnt_q == 4'd7) begin
                            sda_oe <= 1'b0;
                            ptr_q  <= ptr_q + 1'b1;
                            st_q   <= ST_RACK;
                        end else begin
                            shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
                            sda_oe  <= ~shreg_q[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise)
                        mack_q <= ~sda_v;
                    if (scl_fall) begin
                        if (mack_q) begin
                            shreg_q  <= mem_rd;
                            sda_oe   <= ~mem_rd[7];
                            bitcnt_q <= '0;
                            st_q     <= ST_RDATA;
                        end else begin
                            st_q <= ST_IDLE;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/eepemu_chk.sv
// Protocol checker for the EEPROM target model, bound into the top module.
// Assumes it sees the sequencer state and the bus monitor events directly.
module eepemu_chk
    import eepemu_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             scl_i,
    input logic             sda_oe,
    input eep_st_e          st,
    input logic             start_det,
    input logic             stop_det,
    input logic             bus_we,
    input logic [OFF_W-1:0] ptr
);
    // R1: no drive while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_oe);

    // R2: start restarts control decoding
    p_start_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (st == ST_CTRL));

    // R2: stop returns to idle
    p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (st == ST_IDLE));

    // R5: drive begins only while the clock line is low
    p_oe_rise_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // R7: a stored data byte never moves the pointer out of its page
    p_page_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> (ptr[7:4] == $past(ptr[7:4])));
endmodule

bind eepemu_top eepemu_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .st(st_q),
    .start_det(start_det), .stop_det(stop_det), .bus_we(bus_we), .ptr(ptr_q)
);

// File: tb/eepemu_top_bench.sv
`timescale 1ns/1ps
module eepemu_top_bench;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe;
    logic dbg_we = 1'b0;
    logic [8:0] dbg_addr = '0;
    logic [7:0] dbg_wdata = '0;
    logic [7:0] dbg_rdata;
    logic sda_line;
    logic [7:0] model [512];
    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;
    assign sda_line = ~(m_low | sda_oe);

    eepemu_top u_eepemu_top (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hold();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; hold(); m_scl = 1'b1; hold(); m_low = 1'b1; hold(); m_scl = 1'b0; hold();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; hold(); m_scl = 1'b1; hold(); m_low = 1'b0; hold();
    endtask

    task automatic put_bit(input logic b);
        m_low = ~b; hold(); m_scl = 1'b1; hold(); hold(); m_scl = 1'b0; hold();
    endtask

    task automatic get_bit(output logic b);
        m_low = 1'b0; hold(); m_scl = 1'b1; hold(); b = sda_line; hold(); m_scl = 1'b0; hold();
    endtask

    task automatic put_byte(input logic [7:0] v, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        acked = ~a;
    endtask

    task automatic get_byte(output logic [7:0] v, input logic more);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~more);
    endtask

    task automatic dbg_peek(input logic [8:0] a, output logic [7:0] v);
        @(negedge clk);
        dbg_addr = a;
        #1 v = dbg_rdata;
    endtask

    // Random read: dummy write of the offset, repeated start, one byte, no-ack, stop.
    task automatic rand_read(input logic [7:0] ctrl_w, input logic [7:0] off,
                             output logic [7:0] v, output logic all_ack);
        logic a0, a1, a2;
        bus_start();
        put_byte(ctrl_w, a0);
        put_byte(off, a1);
        bus_start();
        put_byte(ctrl_w | 8'h01, a2);
        get_byte(v, 1'b0);
        bus_stop();
        all_ack = a0 & a1 & a2;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic ak, ak2;
        logic [8:0] base;

        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 reset drive", {15'd0, sda_oe}, 16'd0);

        // R12: preload through the debug port
        for (int i = 0; i < 512; i++) begin
            @(negedge clk);
            dbg_we = 1'b1;
            dbg_addr = 9'(i);
            dbg_wdata = 8'((i * 37 + 5) & 255);
            model[i] = 8'((i * 37 + 5) & 255);
        end
        @(negedge clk);
        dbg_we = 1'b0;
        dbg_peek(9'h1A5, v);
        check("R12 debug readback", {8'd0, v}, {8'd0, model[9'h1A5]});

        // R3: wrong device code is not acknowledged and nothing is driven
        bus_start();
        put_byte(8'hB0, ak);
        check("R3 wrong code no ack", {15'd0, ak}, 16'd0);
        put_byte(8'h55, ak);
        check("R3 silent after mismatch", {15'd0, ak}, 16'd0);
        bus_stop();
        check("R1 idle after mismatch", {15'd0, sda_oe}, 16'd0);

        // R3 R8: ignored bits set, random read in bank 0
        rand_read(8'hAC, 8'h33, v, ak);
        check("R3 ignored bits ack", {15'd0, ak}, 16'd1);
        check("R8 random read ignored bits", {8'd0, v}, {8'd0, model[9'h033]});

        // R4 R8 R13: random reads at edges of both banks
        for (int b = 0; b < 2; b++) begin
            for (int k = 0; k < 4; k++) begin
                logic [7:0] off;
                off = (k == 0) ? 8'h00 : (k == 1) ? 8'h7F : (k == 2) ? 8'h80 : 8'hFF;
                rand_read(8'hA0 | 8'(b << 1), off, v, ak);
                check("R5 acks on random read", {15'd0, ak}, 16'd1);
                check("R4 R13 bank read", {8'd0, v}, {8'd0, model[{b[0], off}]});
            end
        end

        // R6 R5: byte write into bank 1
        bus_start();
        put_byte(8'hA2, ak);
        put_byte(8'h40, ak2);
        ak = ak & ak2;
        put_byte(8'h5A, ak2);
        ak = ak & ak2;
        bus_stop();
        model[9'h140] = 8'h5A;
        check("R5 byte write acks", {15'd0, ak}, 16'd1);
        dbg_peek(9'h140, v);
        check("R6 byte write stored", {8'd0, v}, 16'h005A);

        // R7: 20-byte page write from offset 0x1C in bank 0
        bus_start();
        put_byte(8'hA0, ak);
        put_byte(8'h1C, ak2);
        for (int i = 0; i < 20; i++) begin
            put_byte(8'(8'hC0 + i), ak2);
            ak = ak & ak2;
            model[{1'b0, 4'h1, 4'((4'hC + i) & 15)}] = 8'(8'hC0 + i);
        end
        bus_stop();
        check("R7 page write acks", {15'd0, ak}, 16'd1);
        for (int i = 9'h00C; i < 9'h02C; i++) begin
            dbg_peek(9'(i), v);
            check("R7 page wrap region", {7'd0, 9'(i)} << 8 | {8'd0, v},
                  {7'd0, 9'(i)} << 8 | {8'd0, model[i]});
        end

        // R10 R11: sequential read across the bank end in bank 1
        base = 9'h100;
        bus_start();
        put_byte(8'hA2, ak);
        put_byte(8'hF8, ak2);
        bus_start();
        put_byte(8'hA3, ak2);
        for (int i = 0; i < 20; i++) begin
            get_byte(v, (i != 19));
            check("R10 sequential wrap", {8'(i), v},
                  {8'(i), model[base + 9'((8'hF8 + i) & 255)]});
        end
        check("R11 released after no-ack", {15'd0, sda_oe}, 16'd0);
        bus_stop();

        // R9: current-address read continues after the last byte read
        bus_start();
        put_byte(8'hA3, ak);
        get_byte(v, 1'b0);
        bus_stop();
        check("R9 current address after read", {8'd0, v}, {8'd0, model[9'h10C]});

        // R2 R9: address then stop sets pointer without writing
        bus_start();
        put_byte(8'hA0, ak);
        put_byte(8'h55, ak2);
        bus_stop();
        bus_start();
        put_byte(8'hA1, ak);
        get_byte(v, 1'b0);
        bus_stop();
        check("R2 R9 pointer set by stop", {8'd0, v}, {8'd0, model[9'h055]});
        dbg_peek(9'h055, v);
        check("R2 no write on early stop", {8'd0, v}, {8'd0, model[9'h055]});

        // R12: full storage sweep against the bench model
        for (int i = 0; i < 512; i++) begin
            dbg_peek(9'(i), v);
            check("R12 final sweep", {7'd0, 9'(i)} << 8 | {8'd0, v},
                  {7'd0, 9'(i)} << 8 | {8'd0, model[i]});
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule